// File: doc/BRIEF.md
# Packed Signed Saturating Add/Subtract Unit

This unit adds or subtracts two packed vectors of signed integers lane by lane. When a lane overflows, its result is clamped to the largest or smallest value that lane can hold. Lanes are 8, 16, 32 or 64 bits wide. The vector is either 128 bits wide, or 64 bits wide using only the low half. Each accepted operation produces a registered result one cycle later, together with a flag that says whether any active lane was clamped.

A sticky flag collects every clamping event across operations. It stays set until a clear input is asserted, so software can run a batch of operations and then test once whether any of them saturated. The unit never clears the flag on its own.

Overflow is found from sign bits only. Adding two operands of equal sign that give a result of the other sign is an overflow. Subtracting operands of opposite sign that give a result whose sign differs from the first operand is also an overflow. No wide intermediate sum is built.

Top module: `psat_addsub`

## Requirements
- R1: When no lane overflows, each active lane of the result equals the two's-complement wrapped sum (op=0) or difference a-b (op=1) of the matching operand lanes, and sat_op is 0.
- R2: In an addition lane, equal operand signs with a wrapped sum of the other sign is an overflow. The lane becomes the most positive value if the wrapped sum is negative, and the most negative value otherwise.
- R3: In a subtraction lane, opposite operand signs with a wrapped difference whose sign differs from opa's sign is an overflow. The lane becomes the most positive value if the wrapped difference is negative, and the most negative value otherwise.
- R4: lane_sz selects the lane width: 0 for 8, 1 for 16, 2 for 32, 3 for 64 bits. Lane i occupies bits [i*W +: W]. No carry or overflow crosses a lane boundary.
- R5: With wide=0, only bits [63:0] are processed. Result bits [127:64] are 0, and lanes in the upper half never set sat_op or the sticky flag.
- R6: out_valid is high exactly in the cycle after a cycle in which in_valid is high.
- R7: sat_op is 1 for a registered result exactly when at least one active lane of that operation overflowed.
- R8: sat_sticky is set by any overflowing operation and stays set until clr_sticky is high. A clr_sticky cycle with no overflow clears it.
- R9: If clr_sticky and an overflowing operation fall in the same cycle, sat_sticky is 1 afterwards.
- R10: After reset, out_valid, result, sat_op and sat_sticky are all 0.
- R11: While in_valid is low, result and sat_op keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 1 | 0 = add, 1 = subtract (opa - opb) |
| lane_sz | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| wide | input | 1 | 1 = 128-bit vector, 0 = low 64 bits only |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| clr_sticky | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result vector |
| sat_op | output | 1 | Some lane of this result saturated |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Several properties are checked by assertions on every cycle: the valid timing, the hold of the outputs between strobes, the zero upper half in narrow mode, the sticky flag surviving until cleared, saturation winning over a simultaneous clear, and sat_op implying the sticky flag. The clamp values themselves, the sign rules for each lane width and the isolation between lanes can only be shown by the bench. It compares every result against a model that computes the exact sum in a wider signed range and clamps it, over directed corner cases and a broad mix of operand patterns.

// File: rtl/psat_pkg.sv
package psat_pkg;

  typedef enum logic {
    PSAT_ADD = 1'b0,
    PSAT_SUB = 1'b1
  } psat_op_e;

  // Addition overflows when both inputs agree in sign and the result does not.
  function automatic logic add_ovf(input logic sgn_a, input logic sgn_b, input logic sgn_r);
    return (sgn_a == sgn_b) && (sgn_r != sgn_a);
  endfunction

  // Subtraction overflows when the inputs differ in sign and the result
  // leaves the sign of the minuend.
  function automatic logic sub_ovf(input logic sgn_a, input logic sgn_b, input logic sgn_r);
    return (sgn_a != sgn_b) && (sgn_r != sgn_a);
  endfunction

endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o,
  output logic         sat_o
);
  import psat_pkg::*;

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] wrap;
  logic         ovf;

  always_comb begin
    wrap = sub_i ? (a_i - b_i) : (a_i + b_i);
    ovf  = sub_i ? sub_ovf(a_i[W-1], b_i[W-1], wrap[W-1])
                 : add_ovf(a_i[W-1], b_i[W-1], wrap[W-1]);
    // R2 / R3: clamp direction follows the sign of the wrapped value
    if (ovf) r_o = wrap[W-1] ? POS_LIM : NEG_LIM;
    else     r_o = wrap;
    sat_o = ovf;
  end

endmodule

// File: rtl/psat_lane_bank.sv
module psat_lane_bank #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             wide_i,
  output logic [VEC_W-1:0] res_o,
  output logic             sat_o
);
  localparam int unsigned NUM_LANES = VEC_W / LANE_W;
  localparam int unsigned LOW_LANES = NUM_LANES / 2;

  logic [NUM_LANES-1:0] sat_l;

  // R4: each lane is a separate instance, so nothing crosses a boundary
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam bit IN_LOW = (g < LOW_LANES);
    logic [LANE_W-1:0] lane_r;
    logic              lane_sat;
    logic              active;

    psat_lane #(.W(LANE_W)) u_lane (
      .a_i  (a_i[g*LANE_W +: LANE_W]),
      .b_i  (b_i[g*LANE_W +: LANE_W]),
      .sub_i(sub_i),
      .r_o  (lane_r),
      .sat_o(lane_sat)
    );

    // R5: upper-half lanes only take part in wide mode
    assign active = IN_LOW ? 1'b1 : wide_i;
    assign res_o[g*LANE_W +: LANE_W] = active ? lane_r : '0;
    assign sat_l[g] = active & lane_sat;
  end

  assign sat_o = |sat_l;

endmodule

// File: rtl/psat_sticky.sv
module psat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  // R8 / R9: setting has priority over clearing
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/psat_addsub.sv
module psat_addsub #(
  parameter int unsigned VEC_W     = 128,
  parameter int unsigned BASE_LANE = 8,
  parameter int unsigned NUM_SZ    = 4,
  localparam int unsigned SZ_W     = $clog2(NUM_SZ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op,
  input  logic [SZ_W-1:0]  lane_sz,
  input  logic             wide,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic             clr_sticky,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_op,
  output logic             sat_sticky
);
  import psat_pkg::*;

  psat_op_e         op_e;
  logic [VEC_W-1:0] res_sz [NUM_SZ];
  logic [NUM_SZ-1:0] sat_sz;
  logic [VEC_W-1:0] res_sel;
  logic             sat_evt;   // combinational: selected size saturates

  assign op_e = psat_op_e'(op);

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    psat_lane_bank #(
      .VEC_W (VEC_W),
      .LANE_W(BASE_LANE << s)
    ) u_bank (
      .a_i   (opa),
      .b_i   (opb),
      .sub_i (op_e == PSAT_SUB),
      .wide_i(wide),
      .res_o (res_sz[s]),
      .sat_o (sat_sz[s])
    );
  end

  assign res_sel = res_sz[lane_sz];
  assign sat_evt = sat_sz[lane_sz];

  // R6 / R10 / R11: output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_sel;
        sat_op <= sat_evt;
      end
    end
  end

  psat_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (in_valid & sat_evt),
    .clr_i (clr_sticky),
    .flag_q(sat_sticky)
  );

endmodule

// File: rtl/psat_addsub_chk.sv
module psat_addsub_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             wide,
  input logic             clr_sticky,
  input logic             sat_evt,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             sat_op,
  input logic             sat_sticky
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r11_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(sat_op)));
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[VEC_W-1:VEC_W/2] == '0));
  a_r8_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !clr_sticky) |=> sat_sticky);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_evt) |=> sat_sticky);
  a_r7_op_implies_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat_op) |-> sat_sticky);
endmodule

bind psat_addsub psat_addsub_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .wide      (wide),
  .clr_sticky(clr_sticky),
  .sat_evt   (sat_evt),
  .out_valid (out_valid),
  .result    (result),
  .sat_op    (sat_op),
  .sat_sticky(sat_sticky)
);

// File: tb/psat_addsub_tb.sv
`timescale 1ns/1ps
module psat_addsub_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         op = 1'b0;
  logic [1:0]   lane_sz = 2'd0;
  logic         wide = 1'b1;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic         clr_sticky = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_op;
  logic         sat_sticky;

  int compared = 0;
  int mismatched = 0;
  logic exp_sticky = 1'b0;
  logic [127:0] last_res = '0;
  logic last_sat = 1'b0;

  always #2.5 clk = ~clk;

  psat_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .wide(wide), .opa(opa), .opb(opb), .clr_sticky(clr_sticky),
    .out_valid(out_valid), .result(result), .sat_op(sat_op), .sat_sticky(sat_sticky)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model: exact signed sum in a wide range, then clamp.
  task automatic model(input logic sub, input logic [1:0] sz, input logic wd,
                       input logic [127:0] a, input logic [127:0] b,
                       output logic [127:0] res, output logic sat);
    int lw;
    res = '0; sat = 1'b0;
    lw = 8 << sz;
    for (int i = 0; i < 128 / lw; i++) begin
      logic [63:0] ax, bx;
      logic signed [66:0] sa, sb, sum, hi, lo;
      logic [127:0] m;
      if (!wd && (i * lw >= 64)) continue;
      m  = (lw == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << lw) - 128'd1);
      ax = 64'((a >> (i * lw)) & m);
      bx = 64'((b >> (i * lw)) & m);
      sa = $signed({3'b000, ax});
      sb = $signed({3'b000, bx});
      if (ax[lw-1]) sa = sa - (67'sd1 <<< lw);
      if (bx[lw-1]) sb = sb - (67'sd1 <<< lw);
      sum = sub ? (sa - sb) : (sa + sb);
      hi  = (67'sd1 <<< (lw - 1)) - 67'sd1;
      lo  = -(67'sd1 <<< (lw - 1));
      if (sum > hi) begin sum = hi; sat = 1'b1; end
      else if (sum < lo) begin sum = lo; sat = 1'b1; end
      res = res | (((128'(sum[63:0])) & m) << (i * lw));
    end
  endtask

  task automatic do_op(input string tag, input logic sub, input logic [1:0] sz,
                       input logic wd, input logic [127:0] a, input logic [127:0] b,
                       input logic clr);
    logic [127:0] er;
    logic es;
    model(sub, sz, wd, a, b, er, es);
    @(negedge clk);
    in_valid = 1'b1; op = sub; lane_sz = sz; wide = wd; opa = a; opb = b; clr_sticky = clr;
    @(posedge clk);
    #1;
    in_valid = 1'b0; clr_sticky = 1'b0;
    if (clr) exp_sticky = 1'b0;
    if (es) exp_sticky = 1'b1;
    chk({tag, " out_valid R6"}, 128'(out_valid), 128'd1);
    chk({tag, " result"}, result, er);
    chk({tag, " sat_op R7"}, 128'(sat_op), 128'(es));
    chk({tag, " sticky R8"}, 128'(sat_sticky), 128'(exp_sticky));
    last_res = er; last_sat = es;
  endtask

  task automatic t_reset;
    chk("R10 out_valid", 128'(out_valid), 128'd0);
    chk("R10 result", result, 128'd0);
    chk("R10 sat_op", 128'(sat_op), 128'd0);
    chk("R10 sticky", 128'(sat_sticky), 128'd0);
  endtask

  task automatic t_wrap;
    do_op("R1 add8", 1'b0, 2'd0, 1'b1, 128'h0102_0304_0506_0708_1020_3040_FEFD_FC80,
          128'h0101_0101_0101_0101_0101_0101_0102_0300, 1'b0);
    do_op("R1 sub16", 1'b1, 2'd1, 1'b1, 128'h1234_0000_FFFF_8001_0010_7000_0000_1111,
          128'h0234_0001_0001_0001_0020_1000_FFFF_1111, 1'b0);
  endtask

  task automatic t_add_sat;
    do_op("R2 add16", 1'b0, 2'd1, 1'b1, 128'h7FFF_8000_4000_C000_0001_0000_0000_0000,
          128'h0001_FFFF_4000_C000_0001_0000_0000_0000, 1'b0);
    do_op("R2 add64", 1'b0, 2'd3, 1'b1, 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFF0,
          128'h8000_0000_0000_0000_0000_0000_0000_0020, 1'b0);
  endtask

  task automatic t_sub_sat;
    do_op("R3 sub32", 1'b1, 2'd2, 1'b1, 128'h7FFF_FFFF_8000_0000_0000_0000_8000_0000,
          128'hFFFF_FFFF_0000_0001_8000_0000_7FFF_FFFF, 1'b0);
  endtask

  task automatic t_isolation;
    // R4: lane 0 overflows, its neighbours must not see a carry
    do_op("R4 add8", 1'b0, 2'd0, 1'b1, 128'h0000_0000_0000_0000_0000_0000_00FF_FF7F,
          128'h0000_0000_0000_0000_0000_0000_0001_0101, 1'b0);
    do_op("R4 add32", 1'b0, 2'd2, 1'b1, 128'h0000_0000_FFFF_FFFF_0000_0000_FFFF_FFFF,
          128'h0000_0000_0000_0001_0000_0000_0000_0001, 1'b0);
  endtask

  task automatic t_narrow;
    @(negedge clk); clr_sticky = 1'b1; @(posedge clk); #1; clr_sticky = 1'b0;
    exp_sticky = 1'b0;
    // R5: upper half would saturate but is inactive
    do_op("R5 narrow8", 1'b0, 2'd0, 1'b0, 128'h7F7F_7F7F_7F7F_7F7F_0102_0304_0506_0708,
          128'h7F7F_7F7F_7F7F_7F7F_0101_0101_0101_0101, 1'b0);
    chk("R5 upper bits", result[127:64], 128'd0);
    chk("R5 no sticky", 128'(sat_sticky), 128'd0);
  endtask

  task automatic t_sticky;
    do_op("R8 set", 1'b0, 2'd0, 1'b1, 128'h7F, 128'h01, 1'b0);
    do_op("R8 keep", 1'b0, 2'd0, 1'b1, 128'h01, 128'h01, 1'b0);
    @(negedge clk); clr_sticky = 1'b1; @(posedge clk); #1; clr_sticky = 1'b0;
    exp_sticky = 1'b0;
    chk("R8 cleared", 128'(sat_sticky), 128'd0);
    do_op("R9 clr+sat", 1'b1, 2'd1, 1'b1, 128'h8000, 128'h0001, 1'b1);
    chk("R9 set wins", 128'(sat_sticky), 128'd1);
  endtask

  task automatic t_hold;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 idle", 128'(out_valid), 128'd0);
    chk("R11 result held", result, last_res);
    chk("R11 sat held", 128'(sat_op), 128'(last_sat));
  endtask

  task automatic t_mix;
    for (int k = 0; k < 400; k++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (k % 5 == 0) b = a;
      if (k % 7 == 0) b = ~a;
      do_op("R1/R2/R3/R4 mix", 1'(k % 2), 2'(k / 2), 1'(k % 3 != 0), a, b, 1'(k % 11 == 0));
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_wrap();
    t_add_sat();
    t_sub_sat();
    t_isolation();
    t_hold();
    t_narrow();
    t_sticky();
    t_mix();
    t_hold();
    finish_run();
  end
endmodule